// File: doc/BRIEF.md
# Way-Predicting Two-Way Read Cache

This block is a small two-way set-associative read-only cache that sits between a requester and a slower memory. Every set keeps a single guess bit naming the way that is most likely to hold the next address mapped to it. A lookup compares only the guessed way in its first cycle. When the guess is right, the data comes back with the latency of a direct-mapped cache. When the guess is wrong, the other way is compared one cycle later. When both ways miss, the line is fetched over a simple memory port and written into a victim way.

The requester presents an address with a valid/ready handshake and handles one access at a time. Each response carries a two-bit status that tells the requester which of the three paths served it. Three free-running counters record how many accesses took each path, so the rate of correct guesses can be read directly at the ports.

Top module: `wp_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, all three counters read 0, and no line is valid, so the first access to any address is a miss.
- R2: When the guessed way holds the address, `rsp_valid` rises in the first cycle after the accepting clock edge, with `rsp_status` = 0 and the cached data.
- R3: When the guessed way misses and the other way holds the address, `rsp_valid` rises in the second cycle after the accepting edge, with `rsp_status` = 1 and the cached data.
- R4: After a status-1 hit, the set's guess points at the way that hit, so an immediate repeat of that address returns status 0.
- R5: When both ways miss, `mem_req_valid` is raised with `mem_req_addr` equal to the requested address, and both stay unchanged until `mem_req_ready` is sampled high.
- R6: A refill responds in the same cycle that `mem_rsp_valid` is high, with `rsp_status` = 2 and `rsp_data` equal to `mem_rsp_data`. The line is stored in the victim way, and the guess is set to that way. Status code 3 never appears.
- R7: The victim is way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid, otherwise the way named by the set's LRU bit. Every hit or refill sets the LRU bit to the way that was not used.
- R8: `cnt_fast`, `cnt_slow` and `cnt_miss` each increase by one for every response with status 0, 1 and 2 respectively.
- R9: `req_ready` is high only while no access is in progress. It is low from the accepting edge until the response cycle has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Requester presents an address |
| req_ready | output | 1 | Cache is idle and accepts an address |
| req_addr | input | ADDR_W | Read address (low IDX_W bits select the set) |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_status | output | 2 | 0 guessed-way hit, 1 other-way hit, 2 refilled miss |
| rsp_data | output | DATA_W | Read data |
| mem_req_valid | output | 1 | Line fetch request to memory |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_addr | output | ADDR_W | Address of the line to fetch |
| mem_rsp_valid | input | 1 | Memory returns the line |
| mem_rsp_data | input | DATA_W | Returned line data |
| cnt_fast | output | CNT_W | Count of status-0 responses |
| cnt_slow | output | CNT_W | Count of status-1 responses |
| cnt_miss | output | CNT_W | Count of status-2 responses |

## Verification
The assertions assume a well-behaved memory side. The memory raises `mem_rsp_valid` for exactly one cycle, and only after it has accepted a fetch. The requester keeps the address stable while `req_valid` waits for `req_ready`. The bench drives the memory port from inside each access and follows that fetch handshake exactly. It varies the acceptance stall and the return delay with address bits, and it drops `req_valid` right after the accepting edge. A scoreboard of tags, guess bits and LRU bits, written from the requirements, predicts the status, data and counters for a directed conflict sequence and a long pseudo-random sweep over four tags in every set.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [1:0] {
    ST_FAST = 2'd0,
    ST_SLOW = 2'd1,
    ST_FILL = 2'd2
  } wp_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PROBE1,
    S_PROBE2,
    S_MREQ,
    S_MWAIT
  } wp_state_e;

  function automatic logic other_way(input logic w);
    return ~w;
  endfunction

  // Invalid way 0 first, then invalid way 1, then the LRU way.
  function automatic logic pick_victim(input logic v0, input logic v1, input logic lru);
    if (!v0) return 1'b0;
    if (!v1) return 1'b1;
    return lru;
  endfunction

endpackage

// File: rtl/wp_tag_store.sv
module wp_tag_store #(
  parameter int SETS   = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [1:0][TAG_W-1:0]        rd_tag,
  output logic [1:0]                   rd_valid,
  output logic [1:0][DATA_W-1:0]       rd_data,
  input  logic                         wr_en,
  input  logic                         wr_way,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [TAG_W-1:0]             wr_tag,
  input  logic [DATA_W-1:0]            wr_data
);

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [DATA_W-1:0] dat_q [SETS];
    logic [SETS-1:0]   vld_q;
    logic              sel;

    assign sel = wr_en && (wr_way == 1'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_q <= '0;
      else if (sel) vld_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[wr_idx] <= wr_tag;
        dat_q[wr_idx] <= wr_data;
      end
    end

    assign rd_tag[w]   = tag_q[rd_idx];
    assign rd_data[w]  = dat_q[rd_idx];
    assign rd_valid[w] = vld_q[rd_idx];
  end

endmodule

// File: rtl/wp_pred_lru.sv
module wp_pred_lru #(
  parameter int SETS = 4,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic             pred,
  output logic             lru,
  input  logic             upd_en,
  input  logic             used_way
);

  logic [SETS-1:0] pred_q, lru_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q <= '0;
      lru_q  <= '0;
    end else if (upd_en) begin
      pred_q[idx] <= used_way;
      lru_q[idx]  <= wp_pkg::other_way(used_way);
    end
  end

  assign pred = pred_q[idx];
  assign lru  = lru_q[idx];

endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               hit_pred,
  input  logic               hit_other,
  input  logic               mem_req_ready,
  input  logic               mem_rsp_valid,
  output logic               req_ready,
  output logic               accept,
  output logic               in_probe2,
  output logic               rsp_valid,
  output wp_pkg::wp_status_e rsp_status,
  output logic               mem_req_valid,
  output logic               ev_fast,
  output logic               ev_slow,
  output logic               ev_fill,
  output logic               ev_way_miss,
  output logic [CNT_W-1:0]   cnt_fast,
  output logic [CNT_W-1:0]   cnt_slow,
  output logic [CNT_W-1:0]   cnt_miss
);
  import wp_pkg::*;

  wp_state_e st_q, st_d;

  assign req_ready     = (st_q == S_IDLE);
  assign accept        = req_ready && req_valid;
  assign in_probe2     = (st_q == S_PROBE2);
  assign mem_req_valid = (st_q == S_MREQ);
  assign ev_fast       = (st_q == S_PROBE1) && hit_pred;
  assign ev_way_miss   = (st_q == S_PROBE1) && !hit_pred;
  assign ev_slow       = in_probe2 && hit_other;
  assign ev_fill       = (st_q == S_MWAIT) && mem_rsp_valid;
  assign rsp_valid     = ev_fast || ev_slow || ev_fill;

  always_comb begin
    rsp_status = ST_FAST;
    if (ev_slow) rsp_status = ST_SLOW;
    if (ev_fill) rsp_status = ST_FILL;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:   if (accept) st_d = S_PROBE1;
      S_PROBE1: st_d = hit_pred ? S_IDLE : S_PROBE2;
      S_PROBE2: st_d = hit_other ? S_IDLE : S_MREQ;
      S_MREQ:   if (mem_req_ready) st_d = S_MWAIT;
      S_MWAIT:  if (mem_rsp_valid) st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cnt_fast <= '0;
      cnt_slow <= '0;
      cnt_miss <= '0;
    end else begin
      st_q <= st_d;
      if (ev_fast) cnt_fast <= cnt_fast + 1'b1;
      if (ev_slow) cnt_slow <= cnt_slow + 1'b1;
      if (ev_fill) cnt_miss <= cnt_miss + 1'b1;
    end
  end

endmodule

// File: rtl/wp_cache.sv
module wp_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SETS   = 4,
  parameter int CNT_W  = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [CNT_W-1:0]  cnt_fast,
  output logic [CNT_W-1:0]  cnt_slow,
  output logic [CNT_W-1:0]  cnt_miss
);
  import wp_pkg::*;

  logic [ADDR_W-1:0]       addr_q;
  logic [IDX_W-1:0]        idx;
  logic [TAG_W-1:0]        tag;
  logic [1:0][TAG_W-1:0]   way_tag;
  logic [1:0]              way_valid;
  logic [1:0][DATA_W-1:0]  way_data;
  logic                    pred, lru, alt, victim, used_way;
  logic                    hit_pred, hit_other;
  logic                    accept, in_probe2;
  logic                    ev_fast, ev_slow, ev_fill, ev_way_miss;
  wp_status_e              status;

  assign idx = addr_q[IDX_W-1:0];
  assign tag = addr_q[ADDR_W-1:IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  assign alt       = other_way(pred);
  assign hit_pred  = way_valid[pred] && (way_tag[pred] == tag);
  assign hit_other = way_valid[alt] && (way_tag[alt] == tag);
  assign victim    = pick_victim(way_valid[0], way_valid[1], lru);

  always_comb begin
    used_way = pred;
    if (ev_slow) used_way = alt;
    if (ev_fill) used_way = victim;
  end

  always_comb begin
    rsp_data = way_data[pred];
    if (in_probe2) rsp_data = way_data[alt];
    if (ev_fill)   rsp_data = mem_rsp_data;
  end

  assign rsp_status   = status;
  assign mem_req_addr = addr_q;

  wp_tag_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_idx(idx),
    .rd_tag(way_tag), .rd_valid(way_valid), .rd_data(way_data),
    .wr_en(ev_fill), .wr_way(victim), .wr_idx(idx), .wr_tag(tag), .wr_data(mem_rsp_data)
  );

  wp_pred_lru #(.SETS(SETS)) u_pred (
    .clk(clk), .rst_n(rst_n), .idx(idx), .pred(pred), .lru(lru),
    .upd_en(rsp_valid), .used_way(used_way)
  );

  wp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .hit_pred(hit_pred), .hit_other(hit_other),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .req_ready(req_ready), .accept(accept), .in_probe2(in_probe2),
    .rsp_valid(rsp_valid), .rsp_status(status), .mem_req_valid(mem_req_valid),
    .ev_fast(ev_fast), .ev_slow(ev_slow), .ev_fill(ev_fill), .ev_way_miss(ev_way_miss),
    .cnt_fast(cnt_fast), .cnt_slow(cnt_slow), .cnt_miss(cnt_miss)
  );

endmodule

// File: rtl/wp_cache_chk.sv
module wp_cache_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [1:0]        rsp_status,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              ev_way_miss,
  input logic [CNT_W-1:0]  cnt_fast,
  input logic [CNT_W-1:0]  cnt_slow,
  input logic [CNT_W-1:0]  cnt_miss
);

  assert_fast_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd0) |-> $past(req_valid && req_ready));

  assert_slow_after_waymiss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd1) |-> $past(ev_way_miss));

  assert_memreq_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_fill_with_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd2) |-> mem_rsp_valid);

  assert_no_code3_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status != 2'd3));

  assert_cnt_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_fast != $past(cnt_fast)) |-> $past(rsp_valid && rsp_status == 2'd0));

  assert_cnt_slow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_slow != $past(cnt_slow)) |-> $past(rsp_valid && rsp_status == 2'd1));

  assert_cnt_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_miss != $past(cnt_miss)) |-> $past(rsp_valid && rsp_status == 2'd2));

  assert_idle_only_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (rsp_valid || mem_req_valid)));

endmodule

bind wp_cache wp_cache_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .ev_way_miss(ev_way_miss),
  .cnt_fast(cnt_fast), .cnt_slow(cnt_slow), .cnt_miss(cnt_miss)
);

// File: tb/test_wp_cache.sv
`timescale 1ns/1ps
module test_wp_cache;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int SETS   = 4;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic rsp_valid;
  logic [1:0] rsp_status;
  logic [DATA_W-1:0] rsp_data;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0] mem_rsp_data = '0;
  logic [CNT_W-1:0] cnt_fast, cnt_slow, cnt_miss;

  always #2 clk = ~clk;

  wp_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .CNT_W(CNT_W)) i_wp_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_data(rsp_data), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .cnt_fast(cnt_fast), .cnt_slow(cnt_slow),
    .cnt_miss(cnt_miss)
  );

  int vectors = 0;
  int fails   = 0;

  // Scoreboard state, written from the requirements.
  logic [ADDR_W-3:0] m_tag [SETS][2];
  logic              m_vld [SETS][2];
  logic              m_pred [SETS];
  logic              m_lru  [SETS];
  int                m_fast, m_slow, m_miss;

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return 32'h5A00_0000 + (32'(a) * 32'd40503) ^ 32'h0000_3C3C;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < SETS; s++) begin
      m_pred[s] = 1'b0; m_lru[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin m_vld[s][w] = 1'b0; m_tag[s][w] = '0; end
    end
    m_fast = 0; m_slow = 0; m_miss = 0;
  endtask

  // Expected status of one access, updating the scoreboard (R2, R3, R4, R6, R7).
  function automatic int model_access(input logic [ADDR_W-1:0] a);
    int s; logic [ADDR_W-3:0] t; logic p, o, v;
    s = int'(a[1:0]); t = a[ADDR_W-1:2];
    p = m_pred[s]; o = !p;
    if (m_vld[s][p] && m_tag[s][p] == t) begin
      m_lru[s] = o; m_fast++; return 0;
    end
    if (m_vld[s][o] && m_tag[s][o] == t) begin
      m_pred[s] = o; m_lru[s] = p; m_slow++; return 1;
    end
    if (!m_vld[s][0]) v = 1'b0;
    else if (!m_vld[s][1]) v = 1'b1;
    else v = m_lru[s];
    m_vld[s][v] = 1'b1; m_tag[s][v] = t;
    m_pred[s] = v; m_lru[s] = !v; m_miss++;
    return 2;
  endfunction

  task automatic apply_reset();
    rst_n = 1'b0;
    req_valid = 1'b0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    model_reset();
  endtask

  // One access with its memory side; returns observed status.
  task automatic do_access(input logic [ADDR_W-1:0] a, output int st_out);
    int exp_st, lat, phase, stall, dly;
    bit got, seen, busy_bad, held_bad;
    logic [DATA_W-1:0] dat;
    exp_st = model_access(a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(posedge clk);
    #1 req_valid = 1'b0;
    lat = 0; phase = 0; got = 0; seen = 0; busy_bad = 0; held_bad = 0;
    stall = 0; dly = 0; st_out = 3; dat = '0;
    for (int c = 0; c < 40 && !got; c++) begin
      @(negedge clk);
      lat++;
      if (phase == 0) begin
        if (mem_req_valid) begin
          if (!seen) begin
            seen = 1;
            chk(mem_req_addr == a, "R5 fetch address", mem_req_addr, a);
            stall = int'(a[2]);
          end else if (mem_req_addr != a) held_bad = 1;
          if (stall == 0) begin
            mem_req_ready = 1'b1; phase = 1; dly = a[3] ? 2 : 1;
          end else stall--;
        end else if (seen) held_bad = 1;
      end else if (phase == 1) begin
        mem_req_ready = 1'b0;
        dly--;
        if (dly == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = mem_word(a); phase = 2;
        end
      end
      #1;
      if (rsp_valid) begin
        got = 1; st_out = int'(rsp_status); dat = rsp_data;
      end
      if (req_ready && !got) busy_bad = 1;
    end
    @(posedge clk);
    #1 mem_rsp_valid = 1'b0; mem_req_ready = 1'b0;
    chk(got, "R9 response arrives", got, 1);
    chk(!busy_bad, "R9 ready low while busy", busy_bad, 0);
    chk(!held_bad, "R5 fetch held until accepted", held_bad, 0);
    chk(st_out == exp_st, "R2/R3/R6 status", st_out, exp_st);
    chk(dat == mem_word(a), "R2/R3/R6 data", dat, mem_word(a));
    if (exp_st == 0) chk(lat == 1 && !seen, "R2 one-cycle latency", lat, 1);
    if (exp_st == 1) chk(lat == 2 && !seen, "R3 two-cycle latency", lat, 2);
    if (exp_st == 2) chk(seen && phase == 2, "R6 refill via memory", phase, 2);
    chk(cnt_fast == CNT_W'(m_fast), "R8 fast counter", cnt_fast, m_fast);
    chk(cnt_slow == CNT_W'(m_slow), "R8 slow counter", cnt_slow, m_slow);
    chk(cnt_miss == CNT_W'(m_miss), "R8 miss counter", cnt_miss, m_miss);
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int t, input int s);
    return ADDR_W'((t << 2) | s);
  endfunction

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int st;
    int exp_seq [9] = '{2, 0, 2, 1, 0, 2, 1, 2, 1};
    int addr_t  [9] = '{1, 1, 2, 1, 1, 3, 1, 2, 1};
    logic [7:0] lfsr;

    apply_reset();
    #1;
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R1 no fetch after reset", mem_req_valid, 0);
    chk(cnt_fast == 0 && cnt_slow == 0 && cnt_miss == 0, "R1 counters zero",
        cnt_fast + cnt_slow + cnt_miss, 0);

    // Directed conflict sequence in set 1: R4 guess retrain, R7 victim order.
    for (int i = 0; i < 9; i++) begin
      do_access(mk(addr_t[i], 1), st);
      chk(st == exp_seq[i], "R4/R7 directed status", st, exp_seq[i]);
    end

    // Fresh reset: first touch of every set misses (R1), way 0 then way 1 (R7).
    apply_reset();
    for (int s = 0; s < SETS; s++)
      for (int t = 0; t < 3; t++) begin
        do_access(mk(t, s), st);
        chk(st == 2, "R1 cold miss per tag", st, 2);
      end

    // Near-exhaustive sweep: four tags in every set, pseudo-random order.
    lfsr = 8'hA7;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      do_access(ADDR_W'(lfsr[3:0]), st);
    end

    // Tight repeat of one address: every access after the first is fast (R2).
    for (int k = 0; k < 4; k++) do_access(mk(3, 2), st);
    chk(st == 0, "R2 repeated address stays fast", st, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule